// File: doc/BRIEF.md
# Virtual GPIO Pad Configuration Register Bank

This block is a register bank behind a simple single-cycle read/write port. It holds one 32-bit configuration word for each of a parameterised number of virtual GPIO pads (128 by default). Each word packs the pad's output drive value, its synchronised input level, the output-driver and input-receiver disables, a receive trigger mode, an interrupt-select field and a flag that says whether the host owns the pad. Each pad also has a pin input, a pin output and an output enable, all driven from its word.

Software first reads the word at offset 0x00 to learn where the pad words begin. Pad `i` then lives at that base plus `4*i`. A row of lock words reports which pads are frozen: a frozen pad drops every bus write. Lock bits and ownership flags come from parameters at reset and cannot be changed over the bus. Any address that maps to nothing reads as zero and absorbs writes.

Top module: `vgpio_padcfg`

## Requirements
- R1: After reset each pad word has the output-disable bit (bit 3) set, the trigger mode (bits 23:22) at 2 and the output value, input-disable and interrupt-select bits clear. Every `pin_out` and `pin_oe` bit is 0.
- R2: A read of byte address 0x000 returns `PAD_BASE`, the byte offset of the first pad word (0x100 by default).
- R3: Byte address 0x004 + 4*k returns lock word k. Its bit j is the lock state of pad 32*k + j, taken from `LOCK_INIT`.
- R4: Pad i's word is at `PAD_BASE` + 4*i. A write there stores bit 0 (output value), bit 3 (output disable), bit 4 (input disable), bits 21:14 (interrupt select) and bits 23:22 (trigger mode: 0 level, 1 edge, 2 off). A read returns them, and bits 2, 13:5 and 31:28 read as zero.
- R5: A write to a pad whose lock bit is set changes nothing in that pad's word or pins.
- R6: Bit 1 of a pad word shows `pin_in` for that pad through two synchronising flops. Writes to bit 1 are ignored.
- R7: While a pad's input-disable bit is set, its bit 1 reads 0 whatever the pin does.
- R8: `pin_out[i]` equals bit 0 of pad i's word, and `pin_oe[i]` is the inverse of its bit 3.
- R9: Bit 27 (host owned) reads the pad's bit of `OWN_INIT` and cannot be written.
- R10: Reads of unmapped addresses return zero. Writes to unmapped addresses, to offset 0x000 or to the lock words have no effect.
- R11: Read data appears on `rd_data` in the cycle after `rd_en` is sampled and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe for the current address |
| rd_en | input | 1 | Read strobe for the current address |
| addr | input | ADDR_W | Byte address; the two low bits are ignored |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| pin_in | input | NUM_PADS | Per-pad input level, asynchronous |
| pin_out | output | NUM_PADS | Per-pad output value |
| pin_oe | output | NUM_PADS | Per-pad output enable, active high |

## Verification
Directed writes of all ones and all zeros give the full writable mask and the read-only bits in one read each. They separate a wrong field mask from a wrong field placement. Writes to locked pads, to a pad whose ownership flag is clear, and to the base, lock and unmapped ranges are followed by reads and pin checks, which show whether the write gating leaks. Pin toggles with the receiver enabled and then disabled tell the synchronised path apart from a forced zero. A long seeded random mix of writes, reads and pin changes across all pads is compared against a bench model, and it finds wrong pad indexing and cross-pad corruption.

// File: rtl/vgpio_pkg.sv
package vgpio_pkg;
  localparam int WORD_W     = 32;
  localparam int TX_BIT     = 0;
  localparam int RX_BIT     = 1;
  localparam int TXDIS_BIT  = 3;
  localparam int RXDIS_BIT  = 4;
  localparam int INTSEL_LSB = 14;
  localparam int TRIG_LSB   = 22;
  localparam int OWN_BIT    = 27;

  typedef enum logic [1:0] {
    TRIG_LEVEL = 2'd0,
    TRIG_EDGE  = 2'd1,
    TRIG_OFF   = 2'd2,
    TRIG_RSVD  = 2'd3
  } trig_e;

  typedef struct packed {
    logic [7:0] intsel;
    trig_e      trig;
    logic       rx_off;
    logic       tx_off;
    logic       tx_val;
  } pad_cfg_t;

  localparam pad_cfg_t CFG_RESET = '{intsel: 8'h00, trig: TRIG_OFF,
                                     rx_off: 1'b0, tx_off: 1'b1, tx_val: 1'b0};

  function automatic pad_cfg_t cfg_from_word(input logic [WORD_W-1:0] w);
    pad_cfg_t c;
    c.intsel = w[INTSEL_LSB +: 8];
    c.trig   = trig_e'(w[TRIG_LSB +: 2]);
    c.rx_off = w[RXDIS_BIT];
    c.tx_off = w[TXDIS_BIT];
    c.tx_val = w[TX_BIT];
    return c;
  endfunction

  function automatic logic [WORD_W-1:0] word_from_cfg(input pad_cfg_t c,
                                                      input logic rx,
                                                      input logic own);
    logic [WORD_W-1:0] w;
    w                  = '0;
    w[INTSEL_LSB +: 8] = c.intsel;
    w[TRIG_LSB +: 2]   = c.trig;
    w[RXDIS_BIT]       = c.rx_off;
    w[TXDIS_BIT]       = c.tx_off;
    w[TX_BIT]          = c.tx_val;
    w[RX_BIT]          = rx;
    w[OWN_BIT]         = own;
    return w;
  endfunction
endpackage

// File: rtl/vgpio_sync.sv
module vgpio_sync #(
  parameter int W = 128
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1_q;
  logic [W-1:0] s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end

  assign q = s2_q;

  // R6
  sync_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (s2_q == $past(s1_q)));
endmodule

// File: rtl/vgpio_decode.sv
module vgpio_decode #(
  parameter int          ADDR_W     = 12,
  parameter int          NUM_PADS   = 128,
  parameter int unsigned PAD_BASE   = 32'h100,
  parameter int          LOCK_WORDS = 4,
  localparam int         PI_W       = (NUM_PADS   > 1) ? $clog2(NUM_PADS)   : 1,
  localparam int         LI_W       = (LOCK_WORDS > 1) ? $clog2(LOCK_WORDS) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit_base,
  output logic              hit_lock,
  output logic [LI_W-1:0]   lock_idx,
  output logic              hit_pad,
  output logic [PI_W-1:0]   pad_idx
);
  localparam logic [ADDR_W-1:0] PB_W = ADDR_W'(PAD_BASE / 4);
  localparam logic [ADDR_W-1:0] PE_W = ADDR_W'(PAD_BASE / 4 + NUM_PADS);
  localparam logic [ADDR_W-1:0] LE_W = ADDR_W'(LOCK_WORDS);

  logic [ADDR_W-1:0] waddr;
  logic [ADDR_W-1:0] lock_ofs;
  logic [ADDR_W-1:0] pad_ofs;

  always_comb begin
    waddr    = addr >> 2;
    lock_ofs = waddr - ADDR_W'(1);
    pad_ofs  = waddr - PB_W;
    hit_base = (waddr == '0);
    hit_lock = (waddr != '0) && (waddr <= LE_W);
    hit_pad  = (waddr >= PB_W) && (waddr < PE_W);
    lock_idx = LI_W'(lock_ofs);
    pad_idx  = PI_W'(pad_ofs);
  end
endmodule

// File: rtl/vgpio_pad_cell.sv
module vgpio_pad_cell
  import vgpio_pkg::*;
#(
  parameter bit LOCKED = 1'b0,
  parameter bit OWNED  = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_sel,
  input  logic [WORD_W-1:0] wdata,
  input  logic              rx_sync,
  output logic [WORD_W-1:0] word,
  output logic              pin_out,
  output logic              pin_oe
);
  pad_cfg_t cfg_q;
  pad_cfg_t cfg_d;
  logic     upd;

  generate
    if (LOCKED) begin : g_frozen
      assign upd = 1'b0;
    end else begin : g_open
      assign upd = wr_sel;
      // R4
      pad_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_sel |=> (cfg_q == cfg_from_word($past(wdata))));
    end
  endgenerate

  always_comb begin
    cfg_d = cfg_q;
    if (upd) cfg_d = cfg_from_word(wdata);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= CFG_RESET;
    else if (upd) cfg_q <= cfg_d;
  end

  assign word    = word_from_cfg(cfg_q, rx_sync & ~cfg_q.rx_off, OWNED);
  assign pin_out = cfg_q.tx_val;
  assign pin_oe  = ~cfg_q.tx_off;

  // R5
  pad_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_sel || LOCKED) |=> $stable(cfg_q));
endmodule

// File: rtl/vgpio_padcfg.sv
module vgpio_padcfg
  import vgpio_pkg::*;
#(
  parameter int                    NUM_PADS      = 128,
  parameter int                    PADS_PER_WORD = 32,
  parameter int                    ADDR_W        = 12,
  parameter int unsigned           PAD_BASE      = 32'h100,
  parameter logic [NUM_PADS-1:0]   LOCK_INIT     = 128'h8000_0000_0000_0000_0000_0001_0000_0004,
  parameter logic [NUM_PADS-1:0]   OWN_INIT      = 128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_7FFF_FFFF
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [WORD_W-1:0]   wr_data,
  output logic [WORD_W-1:0]   rd_data,
  input  logic [NUM_PADS-1:0] pin_in,
  output logic [NUM_PADS-1:0] pin_out,
  output logic [NUM_PADS-1:0] pin_oe
);
  localparam int LOCK_WORDS = (NUM_PADS + PADS_PER_WORD - 1) / PADS_PER_WORD;
  localparam int PI_W       = (NUM_PADS   > 1) ? $clog2(NUM_PADS)   : 1;
  localparam int LI_W       = (LOCK_WORDS > 1) ? $clog2(LOCK_WORDS) : 1;
  localparam logic [LOCK_WORDS*PADS_PER_WORD-1:0] LOCK_EXT = LOCK_INIT;

  // reset: asserted asynchronously, released through two flops
  logic rst_meta_q;
  logic rst_n_int;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_n_int  <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_n_int  <= rst_meta_q;
    end
  end

  logic              hit_base;
  logic              hit_lock;
  logic [LI_W-1:0]   lock_idx;
  logic              hit_pad;
  logic [PI_W-1:0]   pad_idx;

  vgpio_decode #(
    .ADDR_W(ADDR_W), .NUM_PADS(NUM_PADS), .PAD_BASE(PAD_BASE), .LOCK_WORDS(LOCK_WORDS)
  ) u_dec (
    .addr(addr), .hit_base(hit_base), .hit_lock(hit_lock), .lock_idx(lock_idx),
    .hit_pad(hit_pad), .pad_idx(pad_idx)
  );

  logic [NUM_PADS-1:0] rx_sync;
  vgpio_sync #(.W(NUM_PADS)) u_sync (
    .clk(clk), .rst_n(rst_n_int), .d(pin_in), .q(rx_sync)
  );

  logic [WORD_W-1:0] pad_word [NUM_PADS];

  generate
    for (genvar i = 0; i < NUM_PADS; i++) begin : g_pad
      logic sel;
      assign sel = wr_en && hit_pad && (pad_idx == PI_W'(i));
      vgpio_pad_cell #(.LOCKED(LOCK_INIT[i]), .OWNED(OWN_INIT[i])) u_cell (
        .clk(clk), .rst_n(rst_n_int), .wr_sel(sel), .wdata(wr_data),
        .rx_sync(rx_sync[i]), .word(pad_word[i]),
        .pin_out(pin_out[i]), .pin_oe(pin_oe[i])
      );
    end
  endgenerate

  // read path
  logic [WORD_W-1:0] lock_word;
  logic [WORD_W-1:0] rd_mux;
  logic [WORD_W-1:0] rd_data_d;
  logic [WORD_W-1:0] rd_data_q;

  always_comb begin
    lock_word = '0;
    for (int k = 0; k < LOCK_WORDS; k++) begin
      if (lock_idx == LI_W'(k)) lock_word = WORD_W'(LOCK_EXT[k*PADS_PER_WORD +: PADS_PER_WORD]);
    end
  end

  always_comb begin
    rd_mux = '0;
    if (hit_base)      rd_mux = PAD_BASE;
    else if (hit_lock) rd_mux = lock_word;
    else if (hit_pad)  rd_mux = pad_word[pad_idx];
  end

  always_comb begin
    rd_data_d = rd_data_q;
    if (rd_en) rd_data_d = rd_mux;
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) rd_data_q <= '0;
    else if (rd_en) rd_data_q <= rd_data_d;
  end

  assign rd_data = rd_data_q;

  // R2
  base_read_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    (rd_en && hit_base) |=> (rd_data == PAD_BASE));
  // R10
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    (rd_en && !hit_base && !hit_lock && !hit_pad) |=> (rd_data == '0));
  // R11
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    !rd_en |=> $stable(rd_data));
endmodule

// File: tb/sim_vgpio_padcfg.sv
`timescale 1ns/1ps
module sim_vgpio_padcfg;
  localparam int          NP       = 128;
  localparam int unsigned PBASE    = 32'h100;
  localparam logic [NP-1:0] LOCKS  = 128'h8000_0000_0000_0000_0000_0001_0000_0004;
  localparam logic [NP-1:0] OWNS   = 128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_7FFF_FFFF;
  localparam logic [31:0] WMASK    = 32'h00FF_C019;
  localparam logic [31:0] RST_WORD = 32'h0080_0008;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_en, rd_en;
  logic [11:0]   addr;
  logic [31:0]   wr_data;
  logic [31:0]   rd_data;
  logic [NP-1:0] pin_in, pin_out, pin_oe;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [31:0] mdl [NP];

  always #2 clk = ~clk;

  vgpio_padcfg #(.NUM_PADS(NP), .PAD_BASE(PBASE), .LOCK_INIT(LOCKS), .OWN_INIT(OWNS)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  function automatic logic [31:0] exp_word(input int i);
    logic [31:0] w;
    w = mdl[i];
    w[27] = OWNS[i];
    w[1]  = mdl[i][4] ? 1'b0 : pin_in[i];
    return w;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    if (a >= 12'(PBASE) && a < 12'(PBASE + 4*NP) && !LOCKS[(a - 12'(PBASE)) >> 2])
      mdl[(a - 12'(PBASE)) >> 2] = d & WMASK;
  endtask

  task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic chk_pad(input int i, input string req);
    logic [31:0] d;
    bus_rd(12'(PBASE + 4*i), d);
    chk(d == exp_word(i), req, d, exp_word(i));
  endtask

  task automatic chk_pins(input string req);
    logic [NP-1:0] eo, ee;
    for (int i = 0; i < NP; i++) begin
      eo[i] = mdl[i][0];
      ee[i] = ~mdl[i][3];
    end
    chk(pin_out == eo, req, pin_out, eo);
    chk(pin_oe == ee, req, pin_oe, ee);
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd4711));
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wr_data = '0; pin_in = '0;
    for (int i = 0; i < NP; i++) mdl[i] = RST_WORD;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 / R9: reset words and pins
    for (int i = 0; i < NP; i++) chk_pad(i, "R1_R9 reset word");
    chk_pins("R1 reset pins");

    // R2, R3
    bus_rd(12'h000, d);
    chk(d == PBASE, "R2 base", d, PBASE);
    for (int k = 0; k < 4; k++) begin
      bus_rd(12'(4 + 4*k), d);
      chk(d == LOCKS[32*k +: 32], "R3 lock word", d, LOCKS[32*k +: 32]);
    end

    // R4: full mask and zero, R8 pins
    bus_wr(12'(PBASE + 4*5), 32'hFFFF_FFFF);
    chk_pad(5, "R4 all ones");
    chk_pins("R8 after ones");
    bus_wr(12'(PBASE + 4*5), 32'h0000_0001);
    chk_pad(5, "R4 out enabled");
    chk(pin_oe[5] == 1'b1 && pin_out[5] == 1'b1, "R8 drive", {pin_oe[5], pin_out[5]}, 2'b11);
    bus_wr(12'(PBASE + 4*5), 32'h0040_4000);
    chk_pad(5, "R4 edge mode intsel");

    // R5: locked pads
    bus_wr(12'(PBASE + 4*32), 32'h00FF_C001);
    chk_pad(32, "R5 locked pad 32");
    bus_wr(12'(PBASE + 4*127), 32'h0000_0001);
    chk_pad(127, "R5 locked pad 127");
    chk_pins("R5 locked pins");

    // R6, R7: input path
    pin_in[7] = 1'b1;
    settle();
    chk_pad(7, "R6 input high");
    bus_wr(12'(PBASE + 4*7), 32'h0000_0008);
    chk_pad(7, "R6 rx bit not writable");
    bus_wr(12'(PBASE + 4*7), 32'h0000_0018);
    chk_pad(7, "R7 receiver off");
    pin_in[7] = 1'b0;
    settle();
    chk_pad(7, "R7 input low");

    // R9: ownership read-only
    bus_wr(12'(PBASE + 4*31), 32'h0800_0000);
    chk_pad(31, "R9 unowned stays");
    bus_wr(12'(PBASE + 4*0), 32'h0000_0008);
    chk_pad(0, "R9 owned stays");

    // R10: unmapped and read-only regions
    bus_rd(12'h014, d);
    chk(d == 0, "R10 gap read", d, 0);
    bus_rd(12'h300, d);
    chk(d == 0, "R10 above pads", d, 0);
    bus_rd(12'hFFC, d);
    chk(d == 0, "R10 top", d, 0);
    bus_wr(12'h000, 32'hDEAD_BEEF);
    bus_wr(12'h004, 32'hFFFF_FFFF);
    bus_wr(12'h014, 32'hFFFF_FFFF);
    bus_wr(12'h300, 32'hFFFF_FFFF);
    bus_rd(12'h000, d);
    chk(d == PBASE, "R10 base unwritten", d, PBASE);
    bus_rd(12'h004, d);
    chk(d == LOCKS[31:0], "R10 lock unwritten", d, LOCKS[31:0]);
    for (int i = 0; i < NP; i++) chk_pad(i, "R10 pads untouched");
    chk_pins("R10 pins untouched");

    // R11: read data holds
    bus_rd(12'(PBASE + 4*5), d);
    repeat (3) @(negedge clk);
    chk(rd_data == exp_word(5), "R11 hold", rd_data, exp_word(5));

    // random mix
    for (int n = 0; n < 600; n++) begin
      int op;
      int p;
      op = int'($urandom % 4);
      p  = int'($urandom % NP);
      case (op)
        0: bus_wr(12'(PBASE + 4*p), $urandom);
        1: chk_pad(p, "R4_R5_R6 random read");
        2: begin
          pin_in = {$urandom, $urandom, $urandom, $urandom};
          settle();
        end
        default: chk_pins("R8 random pins");
      endcase
    end
    for (int i = 0; i < NP; i++) chk_pad(i, "R4_R5 final sweep");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule